// File: doc/BRIEF.md
# Flash Command Interface Controller

This block connects a microcontroller byte bus to an on-chip flash array model. Host writes are decoded into multi-cycle command sequences, each opened by a two-write unlock pattern. A read that is not part of a sequence returns array data. After an identify command, reads return a fixed device code or a per-sector protection flag until a reset command is written. After a program or sector-erase command, a cycle-count engine stands in for the embedded algorithm. While it runs, every read returns a status byte instead of array data.

The bus is single-cycle and synchronous. `cs` together with `wr` is one write. `cs` together with `rd` is one read, and its data appears on `rdata` on the clock edge that follows. The default array is 2048 bytes in eight 256-byte sectors. Sector 2 is the only protected sector by default.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset the block is in array read mode, `rdata` is 00h, and the array byte at address a holds a[7:0] XOR {a[10:8], 00000b}.
- R2: In read mode, a read of address a puts the array byte at a on `rdata` one clock later. A read between unlock writes returns array data and does not break the sequence.
- R3: A command is AAh written to 555h, then 55h written to 2AAh, then the command byte written to 555h, with all 11 address bits compared. A write that breaks the pattern drops the decoder back to read mode with no other effect.
- R4: After command 90h, a read with addr[1:0]=01b returns E8h, and a read with addr[1:0]=00b or 11b returns 00h. This identify mode lasts until F0h is written.
- R5: In identify mode, a read with addr[1:0]=10b returns 01h if the sector selected by addr[10:8] is protected, and 00h if it is not.
- R6: Command A0h followed by a data write to address a starts a program. While it runs, status bit 7 reads as the complement of bit 7 of the data being written and bit 5 reads 0. When it ends, the array holds the data and reads return array contents.
- R7: Status bit 6 inverts on each status read and stops once the operation ends.
- R8: The sequence 80h, AAh/555h, 55h/2AAh, then 30h written to an address in a sector, erases that sector to FFh. During the erase, bit 7 reads 0. Bit 3 reads 0 for the first 6 cycles after the 30h write and 1 after that.
- R9: A program that would need any bit to go from 0 to 1 never completes. After 20 busy cycles status bit 5 sets, and reads keep returning status until F0h is written. The array byte is left unchanged.
- R10: A program or erase aimed at a protected sector is dropped: no status, the array is unchanged, and the block is back in read mode.
- R11: Writing F0h returns the block to read mode from any sequence step or from identify mode. Writes during a running program or erase are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select for the current bus cycle |
| rd | input | 1 | Read strobe, qualified by cs |
| wr | input | 1 | Write strobe, qualified by cs |
| addr | input | 11 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A decoder stuck in the wrong state shows on the first read that follows. That read returns E8h where array data was expected, or the reverse, so the fault appears one clock after that read. An engine whose counter or state is wrong shows in status reads. Bit 6 fails to alternate between two back-to-back reads. Bit 3 reads the wrong value inside or after the erase window. Status appears where array data should be, or the array content is wrong a few tens of cycles after the command.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0]  KEY_BYTE1   = 8'hAA;
    localparam logic [7:0]  KEY_BYTE2   = 8'h55;
    localparam logic [10:0] KEY_ADDR1   = 11'h555;
    localparam logic [10:0] KEY_ADDR2   = 11'h2AA;
    localparam logic [7:0]  OP_IDENT    = 8'h90;
    localparam logic [7:0]  OP_PROGRAM  = 8'hA0;
    localparam logic [7:0]  OP_ERASE_SU = 8'h80;
    localparam logic [7:0]  OP_SECT_ERS = 8'h30;
    localparam logic [7:0]  OP_RESET    = 8'hF0;
    localparam logic [7:0]  DEVICE_CODE = 8'hE8;

    typedef enum logic [2:0] {
        DS_READ, DS_KEY1, DS_KEY2, DS_IDENT, DS_PGM, DS_ERS1, DS_ERS2, DS_ERS3
    } dec_state_e;

    typedef enum logic [1:0] {
        EN_IDLE, EN_PGM, EN_ERASE, EN_FAIL
    } eng_state_e;

    typedef struct packed {
        logic       poll;
        logic       toggle;
        logic       error;
        logic       rsv4;
        logic       win_closed;
        logic [2:0] rsv;
    } status_t;

    function automatic logic [7:0] init_byte(input logic [31:0] a);
        return a[7:0] ^ {a[10:8], 5'b0};
    endfunction

endpackage

// File: rtl/fcc_array.sv
module fcc_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              er_en,
    input  logic [SECT_W-1:0] er_sect
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int OFS_W = ADDR_W - SECT_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)
                mem[i] <= init_byte(32'(i));
            else if (er_en && er_sect == SECT_W'(i >> OFS_W))
                mem[i] <= 8'hFF;
            else if (wr_en && wr_addr == ADDR_W'(i))
                mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fcc_seq_decoder.sv
module fcc_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int                    ADDR_W    = 11,
    parameter int                    SECT_W    = 3,
    parameter logic [(1<<SECT_W)-1:0] SECT_PROT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              ident_mode,
    output logic              prog_start,
    output logic              erase_start
);
    dec_state_e st;
    logic k1, k2, prot_hit, is_reset;

    assign k1       = addr[10:0] == KEY_ADDR1;
    assign k2       = addr[10:0] == KEY_ADDR2;
    assign prot_hit = SECT_PROT[addr[ADDR_W-1 -: SECT_W]];
    assign is_reset = wdata == OP_RESET;

    assign ident_mode  = st == DS_IDENT;
    assign prog_start  = wr_en && st == DS_PGM && !is_reset && !prot_hit;
    assign erase_start = wr_en && st == DS_ERS3 && wdata == OP_SECT_ERS && !prot_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= DS_READ;
        end else if (wr_en) begin
            if (is_reset) begin
                st <= DS_READ;
            end else begin
                unique case (st)
                    DS_READ:  st <= (k1 && wdata == KEY_BYTE1) ? DS_KEY1 : DS_READ;
                    DS_KEY1:  st <= (k2 && wdata == KEY_BYTE2) ? DS_KEY2 : DS_READ;
                    DS_KEY2: begin
                        if (!k1)                       st <= DS_READ;
                        else if (wdata == OP_IDENT)    st <= DS_IDENT;
                        else if (wdata == OP_PROGRAM)  st <= DS_PGM;
                        else if (wdata == OP_ERASE_SU) st <= DS_ERS1;
                        else                           st <= DS_READ;
                    end
                    DS_IDENT: st <= DS_IDENT;
                    DS_PGM:   st <= DS_READ;
                    DS_ERS1:  st <= (k1 && wdata == KEY_BYTE1) ? DS_ERS2 : DS_READ;
                    DS_ERS2:  st <= (k2 && wdata == KEY_BYTE2) ? DS_ERS3 : DS_READ;
                    DS_ERS3:  st <= DS_READ;
                    default:  st <= DS_READ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fcc_op_engine.sv
module fcc_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int SECT_W       = 3,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40,
    parameter int ERASE_WIN    = 6,
    parameter int TMO_LIMIT    = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    input  logic [7:0]        cur_byte,
    input  logic              status_rd,
    input  logic              reset_cmd,
    output status_t           status,
    output logic              status_on,
    output logic              eng_idle,
    output logic              arr_wr,
    output logic [ADDR_W-1:0] arr_wa,
    output logic [7:0]        arr_wd,
    output logic              arr_erase,
    output logic [SECT_W-1:0] arr_esect
);
    localparam int MAXC  = (ERASE_CYCLES > TMO_LIMIT) ? ERASE_CYCLES : TMO_LIMIT;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ERASE_CYCLES - 1);
    localparam logic [CNT_W-1:0] T_LIM  = CNT_W'(TMO_LIMIT);
    localparam logic [CNT_W-1:0] W_END  = CNT_W'(ERASE_WIN);

    eng_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] p_addr;
    logic [7:0]        p_data;
    logic              p_ok;
    logic              tgl;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= EN_IDLE;
            cnt    <= '0;
            p_addr <= '0;
            p_data <= '0;
            p_ok   <= 1'b0;
            tgl    <= 1'b0;
        end else begin
            if (status_rd && st != EN_IDLE)
                tgl <= ~tgl;
            unique case (st)
                EN_IDLE: begin
                    cnt <= '0;
                    if (prog_start) begin
                        st     <= EN_PGM;
                        p_addr <= tgt_addr;
                        p_data <= tgt_data;
                        p_ok   <= (tgt_data & ~cur_byte) == 8'h00;
                    end else if (erase_start) begin
                        st     <= EN_ERASE;
                        p_addr <= tgt_addr;
                    end
                end
                EN_PGM: begin
                    cnt <= cnt + 1'b1;
                    if (p_ok && cnt == P_LAST)       st <= EN_IDLE;
                    else if (!p_ok && cnt == T_LIM)  st <= EN_FAIL;
                end
                EN_ERASE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == E_LAST) st <= EN_IDLE;
                end
                EN_FAIL: if (reset_cmd) st <= EN_IDLE;
                default: st <= EN_IDLE;
            endcase
        end
    end

    assign eng_idle  = st == EN_IDLE;
    assign status_on = !eng_idle;
    assign arr_wr    = st == EN_PGM && p_ok && cnt == P_LAST;
    assign arr_wa    = p_addr;
    assign arr_wd    = p_data;
    assign arr_erase = st == EN_ERASE && cnt == E_LAST;
    assign arr_esect = p_addr[ADDR_W-1 -: SECT_W];

    always_comb begin
        status            = '0;
        status.poll       = (st == EN_ERASE) ? 1'b0 : ~p_data[7];
        status.toggle     = tgl;
        status.error      = st == EN_FAIL;
        status.win_closed = st == EN_ERASE && cnt >= W_END;
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int                    ADDR_W       = 11,
    parameter int                    SECT_W       = 3,
    parameter int                    PROG_CYCLES  = 8,
    parameter int                    ERASE_CYCLES = 40,
    parameter int                    ERASE_WIN    = 6,
    parameter int                    TMO_LIMIT    = 20,
    parameter logic [(1<<SECT_W)-1:0] SECT_PROT   = 8'b0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic              rd_en, wr_any, dec_wr;
    logic              ident_mode, prog_start, erase_start;
    logic              status_on, eng_idle, op_err;
    logic              arr_wr, arr_erase;
    logic [ADDR_W-1:0] arr_wa;
    logic [7:0]        arr_wd, arr_rd, ident_byte;
    logic [SECT_W-1:0] arr_esect;
    status_t           status;

    assign rd_en  = cs && rd;
    assign wr_any = cs && wr;
    assign dec_wr = wr_any && eng_idle;
    assign op_err = status.error;

    fcc_seq_decoder #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .SECT_PROT(SECT_PROT)) u_dec (
        .clk(clk), .rst(rst), .wr_en(dec_wr), .addr(addr), .wdata(wdata),
        .ident_mode(ident_mode), .prog_start(prog_start), .erase_start(erase_start)
    );

    fcc_op_engine #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYCLES(PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES), .ERASE_WIN(ERASE_WIN), .TMO_LIMIT(TMO_LIMIT)
    ) u_eng (
        .clk(clk), .rst(rst), .prog_start(prog_start), .erase_start(erase_start),
        .tgt_addr(addr), .tgt_data(wdata), .cur_byte(arr_rd),
        .status_rd(rd_en), .reset_cmd(wr_any && wdata == OP_RESET),
        .status(status), .status_on(status_on), .eng_idle(eng_idle),
        .arr_wr(arr_wr), .arr_wa(arr_wa), .arr_wd(arr_wd),
        .arr_erase(arr_erase), .arr_esect(arr_esect)
    );

    fcc_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_arr (
        .clk(clk), .rst(rst), .rd_addr(addr), .rd_data(arr_rd),
        .wr_en(arr_wr), .wr_addr(arr_wa), .wr_data(arr_wd),
        .er_en(arr_erase), .er_sect(arr_esect)
    );

    always_comb begin
        unique case (addr[1:0])
            2'b01:   ident_byte = DEVICE_CODE;
            2'b10:   ident_byte = {7'b0, SECT_PROT[addr[ADDR_W-1 -: SECT_W]]};
            default: ident_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= status_on  ? status :
                     ident_mode ? ident_byte : arr_rd;
    end
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
    parameter int                    ADDR_W    = 11,
    parameter int                    SECT_W    = 3,
    parameter logic [(1<<SECT_W)-1:0] SECT_PROT = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [7:0]        arr_rd,
    input logic              ident_mode,
    input logic              status_on,
    input logic              prog_start,
    input logic              erase_start,
    input logic              op_err
);
    logic s_rd, hit_prot;
    assign s_rd     = cs && rd && status_on;
    assign hit_prot = SECT_PROT[addr[ADDR_W-1 -: SECT_W]];

    a_r2_array_read: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && !status_on && !ident_mode) |=> rdata == $past(arr_rd));

    a_r4_ident_code: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && !status_on && ident_mode && addr[1:0] == 2'b01) |=> rdata == 8'hE8);

    a_r7_toggle_flip: assert property (@(posedge clk) disable iff (rst)
        ($past(s_rd) && s_rd) |=> rdata[6] != $past(rdata[6]));

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (op_err && !(cs && wr && wdata == 8'hF0)) |=> op_err);

    a_r10_no_protected_start: assert property (@(posedge clk) disable iff (rst)
        (prog_start || erase_start) |-> !hit_prot);

    a_r11_busy_no_start: assert property (@(posedge clk) disable iff (rst)
        status_on |-> !(prog_start || erase_start));
endmodule

bind flash_cmd_ctrl fcc_checker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .SECT_PROT(SECT_PROT)) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .arr_rd(arr_rd), .ident_mode(ident_mode), .status_on(status_on),
    .prog_start(prog_start), .erase_start(erase_start), .op_err(op_err)
);

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        bit         tdiff;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    flash_cmd_ctrl dut (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] model_init(input logic [10:0] a);
        return a[7:0] ^ {a[10:8], 5'b00000};
    endfunction

    // driver: called at a negedge, returns at the next negedge
    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, input logic [7:0] e,
                            input logic [7:0] m, input bit td, input string tag);
        exp_t it;
        it.exp = e; it.mask = m; it.tdiff = td; it.tag = tag;
        sb.push_back(it);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic unlock(input logic [7:0] cmd);
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, cmd);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops an expectation for each read, compares after the edge
    initial begin
        logic [7:0] last = 8'h00;
        forever begin
            @(posedge clk);
            if (cs && rd) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL scoreboard: unexpected read, actual %02h expected none", rdata);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    checks++;
                    if (it.tdiff) begin
                        if (rdata[6] == last[6]) begin
                            fails++;
                            $display("FAIL %s: bit6 actual %0b expected %0b", it.tag, rdata[6], ~last[6]);
                        end
                    end else if ((rdata & it.mask) != (it.exp & it.mask)) begin
                        fails++;
                        $display("FAIL %s: actual %02h expected %02h (mask %02h)",
                                 it.tag, rdata, it.exp, it.mask);
                    end
                end
                last = rdata;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (rdata !== 8'h00) begin
            fails++;
            $display("FAIL R1: rdata actual %02h expected 00", rdata);
        end
        bus_read(11'h7FF, model_init(11'h7FF), 8'hFF, 0, "R1 init pattern");
        // R2 plain reads
        bus_read(11'h010, model_init(11'h010), 8'hFF, 0, "R2 array read");
        bus_read(11'h4C3, model_init(11'h4C3), 8'hFF, 0, "R2 array read");
        // R2 read inside the unlock pattern, R4 identify
        bus_write(11'h555, 8'hAA);
        bus_read(11'h010, model_init(11'h010), 8'hFF, 0, "R2 read inside sequence");
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'h90);
        bus_read(11'h001, 8'hE8, 8'hFF, 0, "R4 device code");
        bus_read(11'h000, 8'h00, 8'hFF, 0, "R4 other ident offset");
        // R5 protection flags
        bus_read(11'h202, 8'h01, 8'hFF, 0, "R5 protected sector");
        bus_read(11'h102, 8'h00, 8'hFF, 0, "R5 open sector");
        bus_write(11'h123, 8'h55);
        bus_read(11'h001, 8'hE8, 8'hFF, 0, "R4 ident persists");
        // R11 F0 leaves identify
        bus_write(11'h000, 8'hF0);
        bus_read(11'h001, model_init(11'h001), 8'hFF, 0, "R11 reset from ident");
        // R3 broken pattern
        bus_write(11'h555, 8'hAA);
        bus_write(11'h123, 8'h55);
        bus_write(11'h555, 8'h90);
        bus_read(11'h001, model_init(11'h001), 8'hFF, 0, "R3 broken unlock");
        // R11 F0 mid-sequence
        bus_write(11'h555, 8'hAA);
        bus_write(11'h555, 8'hF0);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h555, 8'h90);
        bus_read(11'h001, model_init(11'h001), 8'hFF, 0, "R11 reset mid-sequence");
        // R6/R7 program 0x123: 03h -> 01h
        unlock(8'hA0);
        bus_write(11'h123, 8'h01);
        bus_read(11'h123, 8'h80, 8'hA0, 0, "R6 busy poll bit");
        bus_read(11'h123, 8'h00, 8'h00, 1, "R7 toggle flips");
        bus_read(11'h123, 8'h00, 8'h00, 1, "R7 toggle flips");
        idle(15);
        bus_read(11'h123, 8'h01, 8'hFF, 0, "R6 programmed data");
        bus_read(11'h123, 8'h01, 8'hFF, 0, "R7 no status after end");
        // R11 writes during busy ignored
        unlock(8'hA0);
        bus_write(11'h130, 8'h00);
        bus_write(11'h000, 8'hF0);
        bus_read(11'h130, 8'h80, 8'hA0, 0, "R11 busy ignores F0");
        idle(20);
        bus_read(11'h130, 8'h00, 8'hFF, 0, "R11 program completed");
        // R9 failing program 0x124: 04h needs bit7 set
        unlock(8'hA0);
        bus_write(11'h124, 8'h80);
        bus_read(11'h124, 8'h00, 8'hA0, 0, "R9 bit5 clear early");
        idle(30);
        bus_read(11'h124, 8'h20, 8'hA0, 0, "R9 error bit set");
        bus_read(11'h124, 8'h20, 8'hA0, 0, "R9 error sticky");
        bus_write(11'h000, 8'hF0);
        bus_read(11'h124, model_init(11'h124), 8'hFF, 0, "R9 byte unchanged");
        // R10 protected program
        unlock(8'hA0);
        bus_write(11'h250, 8'h00);
        bus_read(11'h250, model_init(11'h250), 8'hFF, 0, "R10 protected program dropped");
        // R8 sector erase of sector 3
        unlock(8'h80);
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h300, 8'h30);
        bus_read(11'h300, 8'h00, 8'h88, 0, "R8 erase window open");
        idle(10);
        bus_read(11'h300, 8'h08, 8'h88, 0, "R8 erase window closed");
        idle(50);
        bus_read(11'h3A5, 8'hFF, 8'hFF, 0, "R8 sector erased");
        bus_read(11'h3FF, 8'hFF, 8'hFF, 0, "R8 sector erased");
        bus_read(11'h2A5, model_init(11'h2A5), 8'hFF, 0, "R8 other sector kept");
        // R10 protected erase
        unlock(8'h80);
        bus_write(11'h555, 8'hAA);
        bus_write(11'h2AA, 8'h55);
        bus_write(11'h200, 8'h30);
        bus_read(11'h2A5, model_init(11'h2A5), 8'hFF, 0, "R10 protected erase dropped");
        idle(4);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule